// File: doc/BRIEF.md
# Pin Edge Timestamp and Sample Packer

The block watches a small group of input pins and turns what it sees into 64-byte capture bursts for a DMA write queue. In timestamp mode, every change of level on pin 0 (rising or falling) records the value of a free-running 32-bit cycle counter as one 32-bit entry. In sampling mode, each pulse on a sample strobe captures the current pin level as 1, 2 or 4 bits, chosen by a two-bit width code. The bits are packed into 32-bit words.

Words go into two alternating 16-word buffers. When one buffer is full, the block raises a transfer request for it and keeps filling the other one. The DMA side reads the full buffer through a word-addressed read port, then pulses a done input. If both buffers are full, any new entry is dropped and a sticky overflow flag is set. Pins are passed through a two-flop synchronizer before any edge detection or sampling.

Top module: `pin_capture_packer`

## Requirements
- R1: After reset, `xfer_req_o` is 0, `xfer_buf_o` is 0 and `overflow_o` is 0.
- R2: With `mode_ts_i`=1, each rising or falling edge of synchronized `pin_i[0]` stores the current free-running counter value as one word. Consecutive entries differ by the number of clock cycles between the pin changes, and 16 edges fill one buffer.
- R3: With `mode_ts_i`=0 and `width_sel_i` equal to 00 or 11, each `sample_stb_i` pulse stores 1 bit (`pin_i[0]`), so 512 samples fill one buffer.
- R4: With `width_sel_i`=01, each strobe stores 2 bits (`pin_i[1:0]`), so 256 samples fill one buffer.
- R5: With `width_sel_i`=10, each strobe stores 4 bits (`pin_i[3:0]`), so 128 samples fill one buffer.
- R6: Samples are packed LSB-first: sample k of a burst sits at bit (k·w mod 32) of word floor(k·w/32), where w is the sample width. Words fill a buffer from address 0 upward.
- R7: Filling a buffer raises `xfer_req_o`, with `xfer_buf_o` naming that buffer (0 or 1), while capture moves on into the other buffer. Only one request is shown at a time, and it is held until `xfer_done_i`. Done frees the buffer and moves `xfer_buf_o` to the other buffer, which is then requested if it is full.
- R8: An entry that arrives while both buffers are full is dropped without changing stored data, and `overflow_o` goes to 1 and stays there until reset.
- R9: In timestamp mode, `sample_stb_i` has no effect. In sampling mode, pin edges alone store nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 4 | Monitored pins, asynchronous |
| sample_stb_i | input | 1 | Sample tick in sampling mode |
| mode_ts_i | input | 1 | 1 = timestamp mode, 0 = sampling mode |
| width_sel_i | input | 2 | Sample width code: 00/11 = 1 bit, 01 = 2 bits, 10 = 4 bits |
| rd_addr_i | input | 4 | Word address in the requested buffer |
| rd_data_o | output | 32 | Word read from the requested buffer (combinational) |
| xfer_req_o | output | 1 | A full buffer waits for transfer |
| xfer_buf_o | output | 1 | Buffer that the request refers to |
| xfer_done_i | input | 1 | One-cycle pulse: the requested buffer has been read |
| overflow_o | output | 1 | Sticky: an entry was dropped |

## Verification
The assertions assume that `mode_ts_i` and `width_sel_i` change only while reset is held, so the bit position inside a word always stays a multiple of the current sample width. They also assume that `xfer_done_i` is pulsed only while a request is shown. The stimulus sets mode and width only inside the reset task and pulses done only after it has seen the request. Pin values are held for at least three cycles before each strobe, so the synchronized level matches the value that was driven.

// File: rtl/pin_capture_pkg.sv
package pin_capture_pkg;
  typedef enum logic [1:0] {
    WSEL_1A = 2'b00,
    WSEL_2  = 2'b01,
    WSEL_4  = 2'b10,
    WSEL_1B = 2'b11
  } wsel_e;

  function automatic logic [2:0] step_of(input logic [1:0] sel);
    case (sel)
      WSEL_2:  step_of = 3'd2;
      WSEL_4:  step_of = 3'd4;
      default: step_of = 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/pin_sync_edge.sv
module pin_sync_edge #(
  parameter int N_PINS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] level_o,
  output logic              edge_o
);
  logic [N_PINS-1:0] s1_q, s2_q;
  logic              s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q[0];
    end
  end

  assign level_o = s2_q;
  assign edge_o  = s2_q[0] ^ s3_q;

  // R2: an edge reflects a pin change two cycles earlier
  p_edge_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(s1_q[0]) != s1_q[0] |=> edge_o);
endmodule

// File: rtl/capture_packer.sv
module capture_packer
  import pin_capture_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int N_PINS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_ts_i,
  input  logic [1:0]        width_sel_i,
  input  logic              sample_stb_i,
  input  logic [N_PINS-1:0] level_i,
  input  logic              edge_i,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int POS_W = $clog2(WORD_W);

  logic [WORD_W-1:0] ts_q, acc_q, acc_n;
  logic [POS_W-1:0]  pos_q;
  logic [POS_W:0]    pos_sum;
  logic [3:0]        samp;
  logic [2:0]        step;
  logic              take, wrap;

  always_comb begin
    step = step_of(width_sel_i);
    case (width_sel_i)
      WSEL_2:  samp = {2'b00, level_i[1:0]};
      WSEL_4:  samp = level_i[3:0];
      default: samp = {3'b000, level_i[0]};
    endcase
    take    = !mode_ts_i && sample_stb_i;
    acc_n   = acc_q | ({{(WORD_W-4){1'b0}}, samp} << pos_q);
    pos_sum = {1'b0, pos_q} + (POS_W+1)'(step);
    wrap    = pos_sum[POS_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_q  <= '0;
      acc_q <= '0;
      pos_q <= '0;
    end else begin
      ts_q <= ts_q + 1'b1;
      if (take) begin
        acc_q <= wrap ? '0 : acc_n;
        pos_q <= pos_sum[POS_W-1:0];
      end
    end
  end

  always_comb begin
    word_valid_o = 1'b0;
    word_o       = acc_n;
    if (mode_ts_i) begin
      word_valid_o = edge_i;
      word_o       = ts_q;
    end else if (take && wrap) begin
      word_valid_o = 1'b1;
    end
  end

  // R4/R5: bit position stays aligned to the sample width
  p_pos_align_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (width_sel_i == WSEL_2) |-> (pos_q[0] == 1'b0));
  p_pos_align_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (width_sel_i == WSEL_4) |-> (pos_q[1:0] == 2'b00));
  // R9: in sampling mode a word only comes out on a strobe
  p_strobe_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_ts_i && word_valid_o) |-> sample_stb_i);
endmodule

// File: rtl/capture_pingpong.sv
module capture_pingpong #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              xfer_req_o,
  output logic              xfer_buf_o,
  input  logic              xfer_done_i,
  output logic              overflow_o
);
  logic [WORD_W-1:0] mem_q [2][DEPTH];
  logic [1:0]        full_q, full_n;
  logic [AW-1:0]     wr_ptr_q;
  logic              fill_q, xbuf_q, ovf_q;
  logic              accept, last, release_buf;

  assign accept      = word_valid_i && !full_q[fill_q];
  assign last        = wr_ptr_q == AW'(DEPTH-1);
  assign release_buf = xfer_done_i && full_q[xbuf_q];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam logic BANK = 1'(b);
    always_ff @(posedge clk_i) begin
      if (accept && fill_q == BANK) mem_q[b][wr_ptr_q] <= word_i;
    end
  end

  always_comb begin
    full_n = full_q;
    if (release_buf) full_n[xbuf_q] = 1'b0;
    if (accept && last) full_n[fill_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q   <= '0;
      wr_ptr_q <= '0;
      fill_q   <= 1'b0;
      xbuf_q   <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      full_q <= full_n;
      if (accept) begin
        wr_ptr_q <= last ? '0 : wr_ptr_q + 1'b1;
        if (last) fill_q <= ~fill_q;
      end
      if (release_buf) xbuf_q <= ~xbuf_q;
      if (word_valid_i && full_q[fill_q]) ovf_q <= 1'b1;
    end
  end

  assign rd_data_o  = mem_q[xbuf_q][rd_addr_i];
  assign xfer_req_o = full_q[xbuf_q];
  assign xfer_buf_o = xbuf_q;
  assign overflow_o = ovf_q;

  // R7: a request holds, on the same buffer, until done
  p_req_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && !xfer_done_i) |=> (xfer_req_o && $stable(xfer_buf_o)));
  // R8: overflow is sticky
  p_no_overflow_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  // R8: an entry arriving while both buffers are full raises overflow
  p_drop_flags_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && full_q == 2'b11) |=> overflow_o);
  // R6: accepted words advance the write address by one
  p_ptr_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !last) |=> (wr_ptr_q == $past(wr_ptr_q) + 1'b1));
endmodule

// File: rtl/pin_capture_packer.sv
module pin_capture_packer #(
  parameter int BURST_BYTES = 64,
  parameter int WORD_W      = 32,
  parameter int N_PINS      = 4,
  localparam int DEPTH      = BURST_BYTES * 8 / WORD_W,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_i,
  input  logic              sample_stb_i,
  input  logic              mode_ts_i,
  input  logic [1:0]        width_sel_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              xfer_req_o,
  output logic              xfer_buf_o,
  input  logic              xfer_done_i,
  output logic              overflow_o
);
  logic [N_PINS-1:0] level;
  logic              pin_edge, word_valid;
  logic [WORD_W-1:0] word;

  pin_sync_edge #(.N_PINS(N_PINS)) u_sync (
    .clk_i, .rst_ni, .pin_i, .level_o(level), .edge_o(pin_edge)
  );

  capture_packer #(.WORD_W(WORD_W), .N_PINS(N_PINS)) u_pack (
    .clk_i, .rst_ni, .mode_ts_i, .width_sel_i, .sample_stb_i,
    .level_i(level), .edge_i(pin_edge),
    .word_valid_o(word_valid), .word_o(word)
  );

  capture_pingpong #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_pp (
    .clk_i, .rst_ni, .word_valid_i(word_valid), .word_i(word),
    .rd_addr_i, .rd_data_o, .xfer_req_o, .xfer_buf_o, .xfer_done_i, .overflow_o
  );

  // R1: nothing is pending on the first cycle after reset
  p_reset_idle_r1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (!xfer_req_o && !overflow_o && !xfer_buf_o));
endmodule

// File: tb/pin_capture_packer_tb_top.sv
module pin_capture_packer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  pin = '0;
  logic        stb = 1'b0, mode_ts = 1'b0, done = 1'b0;
  logic [1:0]  wsel = 2'b00;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        req, xbuf, ovf;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_w [16];
  logic [31:0] got_w [16];

  // {width code, multiplier, offset}
  localparam logic [9:0] VEC [6] = '{
    {2'b00, 4'd3, 4'd1}, {2'b01, 4'd5, 4'd2}, {2'b10, 4'd7, 4'd9},
    {2'b11, 4'd1, 4'd0}, {2'b01, 4'd11, 4'd6}, {2'b10, 4'd13, 4'd4}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_capture_packer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .sample_stb_i(stb),
    .mode_ts_i(mode_ts), .width_sel_i(wsel), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .xfer_req_o(req), .xfer_buf_o(xbuf),
    .xfer_done_i(done), .overflow_o(ovf)
  );

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic do_reset(input logic m, input logic [1:0] w);
    @(negedge clk);
    rst_n = 1'b0; mode_ts = m; wsel = w; pin = '0; stb = 1'b0; done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic sample(input logic [3:0] v);
    @(negedge clk); pin = v;
    repeat (2) @(negedge clk);
    stb = 1'b1;
    @(negedge clk); stb = 1'b0;
  endtask

  task automatic toggle(input int gap);
    @(negedge clk); pin[0] = ~pin[0];
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic read_all();
    for (int a = 0; a < 16; a++) begin
      @(negedge clk); rd_addr = 4'(a);
      #1 got_w[a] = rd_data;
    end
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
    @(negedge clk);
  endtask

  function automatic int gap_of(input int i);
    return 3 + (i % 4);
  endfunction

  function automatic string tag_of(input logic [1:0] w);
    case (w)
      2'b01:   return "R4 R6";
      2'b10:   return "R5 R6";
      default: return "R3 R6";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int w, ns, mul, add, mask, v, bp, e;
    // R1: reset state
    do_reset(1'b0, 2'b00);
    chk(req == 1'b0, "R1 req", 32'(req), 0);
    chk(xbuf == 1'b0, "R1 buf", 32'(xbuf), 0);
    chk(ovf == 1'b0, "R1 ovf", 32'(ovf), 0);

    // R3/R4/R5/R6: table-driven sampling bursts
    for (int t = 0; t < 6; t++) begin
      do_reset(1'b0, VEC[t][9:8]);
      w = (VEC[t][9:8] == 2'b01) ? 2 : (VEC[t][9:8] == 2'b10) ? 4 : 1;
      mask = (1 << w) - 1;
      mul = int'(VEC[t][7:4]); add = int'(VEC[t][3:0]);
      ns = 512 / w;
      for (int i = 0; i < 16; i++) exp_w[i] = '0;
      for (int k = 0; k < ns; k++) begin
        v = ((k * mul + add) ^ (k >> 2)) & mask;
        bp = k * w;
        for (int b = 0; b < w; b++)
          exp_w[bp / 32][(bp % 32) + b] = v[b];
        sample(4'(v));
        if (k == ns - 2) chk(req == 1'b0, {tag_of(VEC[t][9:8]), " early req"}, 32'(req), 0);
      end
      repeat (3) @(negedge clk);
      chk(req == 1'b1, {tag_of(VEC[t][9:8]), " R7 req"}, 32'(req), 1);
      chk(xbuf == 1'b0, "R7 buf", 32'(xbuf), 0);
      read_all();
      for (int i = 0; i < 16; i++)
        chk(got_w[i] == exp_w[i], tag_of(VEC[t][9:8]), got_w[i], exp_w[i]);
    end

    // R9: edges ignored in sampling mode
    do_reset(1'b0, 2'b00);
    for (int i = 0; i < 600; i++) toggle(2);
    repeat (4) @(negedge clk);
    chk(req == 1'b0, "R9 sampling edges", 32'(req), 0);
    chk(ovf == 1'b0, "R9 sampling ovf", 32'(ovf), 0);

    // R2/R7/R8/R9: timestamp mode
    do_reset(1'b1, 2'b00);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk); stb = 1'b1; @(negedge clk); stb = 1'b0;
    end
    chk(req == 1'b0, "R9 ts strobes", 32'(req), 0);
    e = 0;
    for (int i = 0; i < 16; i++) begin toggle(gap_of(e)); e++; end
    repeat (5) @(negedge clk);
    chk(req == 1'b1, "R2 req after 16 edges", 32'(req), 1);
    read_all();
    for (int i = 1; i < 16; i++)
      chk(got_w[i] - got_w[i-1] == 32'(gap_of(i - 1)), "R2 delta", got_w[i] - got_w[i-1], 32'(gap_of(i - 1)));
    for (int i = 0; i < 16; i++) begin toggle(gap_of(e)); e++; end
    repeat (5) @(negedge clk);
    chk(req == 1'b1 && xbuf == 1'b0, "R7 single request", {30'd0, req, xbuf}, 32'b10);
    chk(ovf == 1'b0, "R8 no ovf yet", 32'(ovf), 0);
    for (int i = 0; i < 4; i++) toggle(5);
    repeat (5) @(negedge clk);
    chk(ovf == 1'b1, "R8 ovf set", 32'(ovf), 1);
    pulse_done();
    chk(req == 1'b1 && xbuf == 1'b1, "R7 next buffer", {30'd0, req, xbuf}, 32'b11);
    read_all();
    for (int i = 1; i < 16; i++)
      chk(got_w[i] - got_w[i-1] == 32'(gap_of(15 + i)), "R8 data kept", got_w[i] - got_w[i-1], 32'(gap_of(15 + i)));
    pulse_done();
    chk(req == 1'b0, "R7 released", 32'(req), 0);
    chk(ovf == 1'b1, "R8 sticky", 32'(ovf), 1);
    do_reset(1'b1, 2'b00);
    chk(ovf == 1'b0, "R1 R8 cleared by reset", 32'(ovf), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule